// File: doc/BRIEF.md
# Double-Precision Compare-to-Mask Unit

This block compares two IEEE-754 binary64 operands, A and B, under one of four selectable predicates and turns the outcome into a 128-bit lane mask for a vector destination. A true predicate writes ones across the high 64-bit lane and zeros across the low lane. A false predicate writes zeros across all 128 bits. Alongside the mask it reports two invalid-operation flag pulses. One flag marks a signaling NaN operand. The other marks an invalid ordered comparison. Both pulses are meant for a sticky status register kept outside this block.

Each operation is presented on the input stream by one cycle of `in_vld`. It carries the predicate code, both operands, the current destination contents and the invalid-exception-enable bit. The block has no ready signal. It accepts an operation in every cycle and never applies back-pressure, so the consumer must take each result in the cycle `res_vld` is high. The result appears one clock after the operation is accepted.

When invalid exceptions are enabled and either flag fires, the destination write is suppressed. In that case `res_we` stays low and `res_data` carries back the destination value that was supplied with the operation.

Top module: `dpcmp_mask`

## Requirements
- R1: `pred_sel` encodes the predicate as follows: 0 is A equal to B, 1 is A greater than B (evaluated as B < A), 2 is A greater than or equal to B (evaluated as B <= A), and 3 is A not equal to B (the inverse of equal).
- R2: In the cycle after `in_vld` is high, when the write is not suppressed, `res_vld` and `res_we` are 1. `res_data` is then {64 ones, 64 zeros} if the predicate holds and all zeros if it does not.
- R3: NaN operands are unordered, so equal, greater-than and greater-or-equal evaluate false and not-equal evaluates true. +0 and -0 compare equal. Infinities order normally.
- R4: `flag_snan` pulses for one cycle after any accepted operation in which either operand is a signaling NaN, whatever the predicate.
- R5: For predicates 1 and 2, `flag_vcmp` pulses when either operand is a quiet NaN and neither operand is a signaling NaN.
- R6: For predicates 1 and 2 with a signaling NaN operand, `flag_vcmp` pulses only when `inv_en` is 0.
- R7: Predicates 0 and 3 never raise `flag_vcmp`.
- R8: When `inv_en` is 1 and either flag fires, `res_we` is 0, `res_vld` is 1, and `res_data` equals the `dst_old` supplied with the operation. The flags are still reported.
- R9: In the cycle after `in_vld` is low, `res_vld`, `res_we`, `flag_snan` and `flag_vcmp` are all 0.
- R10: While `rst_n` is low, every output is 0.
- R11: A value is a NaN when its 11-bit exponent field (bits 62:52) is all ones and its fraction (bits 51:0) is nonzero. Such a NaN is signaling when bit 51 is 0 and quiet when bit 51 is 1. Infinity (zero fraction) is not a NaN and raises no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operation present this cycle |
| pred_sel | input | 2 | Predicate code (R1) |
| opa | input | 64 | Operand A, binary64 |
| opb | input | 64 | Operand B, binary64 |
| dst_old | input | 128 | Current destination value |
| inv_en | input | 1 | Invalid-operation exception enable |
| res_vld | output | 1 | Result present this cycle |
| res_data | output | 128 | Lane mask or preserved destination |
| res_we | output | 1 | Destination write enable |
| flag_snan | output | 1 | Signaling-NaN invalid pulse |
| flag_vcmp | output | 1 | Invalid-compare pulse |

## Verification
The bench targets signed zeros, infinities, subnormals and negative operands, where a plain unsigned compare of the bit patterns would misorder values or call -0 and +0 unequal. It also sweeps quiet and signaling NaNs of both signs through every predicate with the enable at both values. A design that gets these wrong would return true for ordered NaN compares, fail to invert for not-equal, or flag invalid-compare on the equality predicates. It also exercises the case of a signaling NaN on a greater-than predicate with the enable set, where a wrong design would raise the invalid-compare flag or still write the mask instead of returning the old destination. Idle cycles between operations expose flags or write enables that linger after the strobe drops.

// File: rtl/dpcmp_pkg.sv
package dpcmp_pkg;
  typedef enum logic [1:0] {
    PR_EQ = 2'd0,
    PR_GT = 2'd1,
    PR_GE = 2'd2,
    PR_NE = 2'd3
  } pred_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_qnan;
    logic is_zero;
  } fcls_t;
endpackage

// File: rtl/dpc_classify.sv
module dpc_classify
  import dpcmp_pkg::*;
#(
  parameter int DW   = 64,
  parameter int EXPW = 11
) (
  input  logic [DW-1:0] val,
  output fcls_t         cls
);
  localparam int FRACW = DW - 1 - EXPW;
  localparam int QBIT  = FRACW - 1;

  logic [EXPW-1:0]  exp_f;
  logic [FRACW-1:0] frac_f;
  logic             exp_max;
  logic             frac_nz;

  assign exp_f   = val[DW-2 -: EXPW];
  assign frac_f  = val[FRACW-1:0];
  assign exp_max = &exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    cls.is_nan  = exp_max && frac_nz;
    cls.is_qnan = exp_max && frac_f[QBIT];
    cls.is_snan = exp_max && frac_nz && !frac_f[QBIT];
    cls.is_zero = ~|val[DW-2:0];
  end

  // R11: exactly one NaN kind for any NaN, none otherwise
  always_comb begin
    p_nan_kind_r11: assert (cls.is_nan == (cls.is_snan ^ cls.is_qnan));
  end
endmodule

// File: rtl/dpc_order.sv
module dpc_order
  import dpcmp_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  fcls_t         cls_a,
  input  fcls_t         cls_b,
  output logic          b_eq_a,
  output logic          b_lt_a
);
  localparam int MW = DW - 1;

  logic          sa, sb;
  logic [MW-1:0] ma, mb;
  logic          unord, both_zero, mag_lt, mag_gt;

  assign sa        = opa[DW-1];
  assign sb        = opb[DW-1];
  assign ma        = opa[MW-1:0];
  assign mb        = opb[MW-1:0];
  assign unord     = cls_a.is_nan || cls_b.is_nan;
  assign both_zero = cls_a.is_zero && cls_b.is_zero;
  assign mag_lt    = mb < ma;
  assign mag_gt    = mb > ma;

  always_comb begin
    b_eq_a = !unord && (both_zero || (opa == opb));
    b_lt_a = 1'b0;
    if (!unord && !both_zero) begin
      unique case ({sb, sa})
        2'b10:   b_lt_a = 1'b1;
        2'b01:   b_lt_a = 1'b0;
        2'b00:   b_lt_a = mag_lt;
        default: b_lt_a = mag_gt;
      endcase
    end
  end

  // R1/R3: equality and strict less-than are exclusive
  always_comb begin
    p_eq_lt_excl_r3: assert (!(b_eq_a && b_lt_a));
  end
endmodule

// File: rtl/dpcmp_mask.sv
module dpcmp_mask
  import dpcmp_pkg::*;
#(
  parameter int DW   = 64,
  parameter int EXPW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [1:0]      pred_sel,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  input  logic [2*DW-1:0] dst_old,
  input  logic            inv_en,
  output logic            res_vld,
  output logic [2*DW-1:0] res_data,
  output logic            res_we,
  output logic            flag_snan,
  output logic            flag_vcmp
);
  localparam int RW   = 2 * DW;
  localparam int NOPS = 2;

  logic [DW-1:0] ops [NOPS];
  fcls_t         cls [NOPS];

  assign ops[0] = opa;
  assign ops[1] = opb;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    dpc_classify #(.DW(DW), .EXPW(EXPW)) u_cls (
      .val (ops[g]),
      .cls (cls[g])
    );
  end

  logic b_eq_a, b_lt_a;

  dpc_order #(.DW(DW)) u_ord (
    .opa    (opa),
    .opb    (opb),
    .cls_a  (cls[0]),
    .cls_b  (cls[1]),
    .b_eq_a (b_eq_a),
    .b_lt_a (b_lt_a)
  );

  pred_e         pred;
  logic          snan_any, qnan_any, ordered_pred;
  logic          vc_n, hit, block;
  logic [RW-1:0] mask_n;

  assign pred         = pred_e'(pred_sel);
  assign snan_any     = cls[0].is_snan || cls[1].is_snan;
  assign qnan_any     = cls[0].is_qnan || cls[1].is_qnan;
  assign ordered_pred = (pred == PR_GT) || (pred == PR_GE);
  assign vc_n         = ordered_pred && (snan_any ? !inv_en : qnan_any);
  assign block        = inv_en && (snan_any || vc_n);

  always_comb begin
    unique case (pred)
      PR_EQ:   hit = b_eq_a;
      PR_GT:   hit = b_lt_a;
      PR_GE:   hit = b_lt_a || b_eq_a;
      default: hit = !b_eq_a;
    endcase
    mask_n = hit ? {{DW{1'b1}}, {DW{1'b0}}} : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      res_data  <= '0;
      res_we    <= 1'b0;
      flag_snan <= 1'b0;
      flag_vcmp <= 1'b0;
    end else begin
      res_vld   <= in_vld;
      res_we    <= in_vld && !block;
      flag_snan <= in_vld && snan_any;
      flag_vcmp <= in_vld && vc_n;
      if (in_vld) res_data <= block ? dst_old : mask_n;
    end
  end

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!res_vld && !res_we && !flag_snan && !flag_vcmp));

  p_mask_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (res_data[DW-1:0] == '0 &&
                (res_data[RW-1:DW] == '0 || &res_data[RW-1:DW])));

  p_hold_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_we) |-> (res_data == $past(dst_old)));

  p_block_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_we) |-> (flag_snan || flag_vcmp));

  p_no_vc_eqne_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (pred == PR_EQ || pred == PR_NE)) |=> !flag_vcmp);

  p_snan_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && snan_any) |=> flag_snan);
endmodule

// File: tb/dpcmp_mask_tb_top.sv
module dpcmp_mask_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [1:0]   pred_sel = '0;
  logic [63:0]  opa = '0, opb = '0;
  logic [127:0] dst_old = '0;
  logic         inv_en = 1'b0;
  logic         res_vld, res_we, flag_snan, flag_vcmp;
  logic [127:0] res_data;

  int n_run = 0, n_fail = 0;

  typedef struct {
    logic [127:0] data;
    logic         we, fs, fv;
    string        tag;
  } exp_t;
  exp_t sb_q[$];

  localparam logic [63:0] P1  = 64'h3FF0000000000000;
  localparam logic [63:0] P2  = 64'h4000000000000000;
  localparam logic [63:0] N1  = 64'hBFF0000000000000;
  localparam logic [63:0] N2  = 64'hC000000000000000;
  localparam logic [63:0] PZ  = 64'h0000000000000000;
  localparam logic [63:0] NZ  = 64'h8000000000000000;
  localparam logic [63:0] PI  = 64'h7FF0000000000000;
  localparam logic [63:0] NI  = 64'hFFF0000000000000;
  localparam logic [63:0] QN  = 64'h7FF8000000000000;
  localparam logic [63:0] NQN = 64'hFFF8000000000123;
  localparam logic [63:0] SN  = 64'h7FF0000000000001;
  localparam logic [63:0] NSN = 64'hFFF4000000000000;
  localparam logic [63:0] SUB = 64'h0000000000000001;
  localparam logic [127:0] OLD = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_5555_AAAA;
  localparam logic [127:0] TRUE_M = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0};

  dpcmp_mask dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .pred_sel(pred_sel),
    .opa(opa), .opb(opb), .dst_old(dst_old), .inv_en(inv_en),
    .res_vld(res_vld), .res_data(res_data), .res_we(res_we),
    .flag_snan(flag_snan), .flag_vcmp(flag_vcmp)
  );

  always #10 clk = ~clk;

  function automatic bit is_nan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction
  function automatic bit is_snan(logic [63:0] v);
    return is_nan(v) && !v[51];
  endfunction

  task automatic check(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: computes expected outcome from the requirements, queues it
  task automatic op(logic [1:0] p, logic [63:0] a, logic [63:0] b, logic en, string tag);
    exp_t e;
    real ra, rb;
    bit hit, sn, qn, vc, blk;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    case (p)
      2'd0: hit = (rb == ra);
      2'd1: hit = (rb < ra);
      2'd2: hit = (rb <= ra);
      default: hit = !(rb == ra);
    endcase
    sn  = is_snan(a) || is_snan(b);
    qn  = (is_nan(a) && !is_snan(a)) || (is_nan(b) && !is_snan(b));
    vc  = (p == 2'd1 || p == 2'd2) && (sn ? !en : qn);
    blk = en && (sn || vc);
    e.data = blk ? OLD : (hit ? TRUE_M : 128'h0);
    e.we = !blk; e.fs = sn; e.fv = vc; e.tag = tag;
    @(negedge clk);
    in_vld = 1'b1; pred_sel = p; opa = a; opb = b; inv_en = en; dst_old = OLD;
    sb_q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_vld = 1'b0; opa = QN; opb = SN; inv_en = 1'b0; pred_sel = 2'd1;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_vld) begin
        if (sb_q.size() == 0) begin
          check("R2", "unexpected res_vld", 128'(res_vld), 128'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(e.tag, "res_data", res_data, e.data);
          check(e.tag, "res_we", 128'(res_we), 128'(e.we));
          check(e.tag, "flag_snan", 128'(flag_snan), 128'(e.fs));
          check(e.tag, "flag_vcmp", 128'(flag_vcmp), 128'(e.fv));
        end
      end else begin
        check("R9", "idle we/flags", {125'd0, res_we, flag_snan, flag_vcmp}, 128'd0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset outputs",
          {res_data ^ 128'h0, 124'd0} | {124'd0, res_vld, res_we, flag_snan, flag_vcmp}, 128'd0);
    rst_n = 1'b1;
    idle(2);
    // R1/R2 ordinary ordering
    op(2'd0, P1, P1, 1'b0, "R1_eq_true");
    op(2'd0, P1, P2, 1'b0, "R1_eq_false");
    op(2'd1, P2, P1, 1'b0, "R1_gt_true");
    op(2'd1, P1, P1, 1'b0, "R1_gt_equal");
    op(2'd1, P1, P2, 1'b0, "R1_gt_false");
    op(2'd2, P1, P1, 1'b0, "R1_ge_equal");
    op(2'd2, N2, N1, 1'b0, "R1_ge_neg");
    op(2'd3, P1, P2, 1'b0, "R1_ne_true");
    op(2'd3, N1, N1, 1'b0, "R1_ne_false");
    op(2'd1, N1, N2, 1'b0, "R2_gt_negs");
    op(2'd1, P1, N1, 1'b0, "R2_gt_mixsign");
    op(2'd1, SUB, PZ, 1'b0, "R2_gt_subnormal");
    idle(1);
    // R3 zeros and infinities
    op(2'd0, PZ, NZ, 1'b0, "R3_zero_eq");
    op(2'd1, PZ, NZ, 1'b0, "R3_zero_gt");
    op(2'd3, NZ, PZ, 1'b0, "R3_zero_ne");
    op(2'd1, PI, P2, 1'b0, "R3_inf_gt");
    op(2'd2, NI, N2, 1'b1, "R3_neginf_ge");
    op(2'd0, PI, PI, 1'b1, "R11_inf_not_nan");
    // quiet NaN
    for (int p = 0; p < 4; p++) begin
      op(2'(p), QN, P1, 1'b0, "R5_qnan_a");
      op(2'(p), P1, NQN, 1'b0, "R3_qnan_b");
    end
    for (int p = 0; p < 4; p++) op(2'(p), QN, QN, 1'b1, "R8_qnan_en");
    idle(2);
    // signaling NaN, both enables
    for (int en = 0; en < 2; en++) begin
      for (int p = 0; p < 4; p++) begin
        op(2'(p), SN, P1, 1'(en), "R4_snan_a");
        op(2'(p), P1, NSN, 1'(en), "R6_snan_b");
        op(2'(p), SN, QN, 1'(en), "R7_snan_qnan");
      end
    end
    op(2'd1, SN, P2, 1'b1, "R8_gt_snan_en");
    idle(1);
    op(2'd0, P2, P2, 1'b1, "R8_en_no_nan");
    idle(4);
    if (sb_q.size() != 0) check("R2", "leftover results", 128'(sb_q.size()), 128'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule